// File: doc/BRIEF.md
# Programmable Raster Sync and Border Generator

This block is the timing core of a character-based display controller. It holds three counters. The first is a horizontal character counter. The second is a raster-row counter inside each character row. The third is a vertical character-row counter. The block advances them on a character-clock enable and compares them against programmed values to produce horizontal sync, vertical sync and a display-enable signal that is low during the border. The counter values are brought out so that a neighbouring address generator can form memory addresses from them.

The programmed values arrive as plain input buses from the host register file. These values are:
- line total
- displayed characters per line
- horizontal sync position
- a packed sync-width byte
- vertical total and adjust lines
- displayed rows
- vertical sync row
- a mode byte
- maximum raster row

Display enable combines a horizontal border flag, a vertical border flag and a forced-border condition. Two bits of the mode byte can delay display enable by one or two characters, or hold it low.

Three parameters select variant behaviour:
- what a zero horizontal sync width means
- whether the vertical sync width is taken from the register or fixed at 16 lines
- whether the vertical border compare runs on every character or only at the start of each character row

Top module: `raster_timing_gen`

## Requirements
- R1: On each enabled character, `h_count` increments, and it returns to 0 on the character after it equals `h_total`.
- R2: `row_count` advances when the line wraps and runs from 0 to `row_max`. When it wraps, `v_count` increments. After the row in which `v_count` equals `v_total`, `v_adjust` extra lines follow, with `v_count` held at `v_total` and `row_count` counting them from 0. The frame then restarts at `v_count`=0, `row_count`=0. With `v_adjust`=0 the frame restarts directly.
- R3: While `ce` is low, no counter or output changes.
- R4: `hsync` rises on the character where `h_count` becomes `h_sync_pos` and stays high for `sync_widths[3:0]` characters. A width of 0 gives 16 characters when `ZERO_HSYNC_OFF`=0 and no pulse when it is 1.
- R5: `vsync` rises at the first character of the line where `v_count`=`v_sync_pos` and `row_count`=0, outside the adjust lines. It lasts `sync_widths[7:4]` lines, with 0 meaning 16. When `FIXED_VSYNC`=1 the width is always 16 lines.
- R6: The horizontal border flag sets when `h_count` reaches `h_disp` and clears when `h_count` reaches 0. The vertical border flag sets when `v_count` reaches `v_disp` and clears at `v_count` 0. With `mode_ctl[5:4]`=00, `disp_en` is high only when both flags are clear.
- R7: `mode_ctl[5:4]` sets display-enable skew: 00 none, 01 one character late, 10 two characters late, 11 `disp_en` forced low.
- R8: With `VB_ROW_START`=0 the vertical border compare acts on every enabled character. With 1 it acts only when the new position is `h_count`=0 and `row_count`=0, so a mid-row change of `v_disp` has no effect until the next row start.
- R9: `mode_ctl[1:0]` has no effect; timing is always non-interlaced.
- R10: Synchronous reset clears all three counters, `hsync` and `vsync`, and sets both border flags, so `disp_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Character clock enable |
| h_total | input | HCW | Last horizontal count of a line |
| h_disp | input | HCW | Displayed characters per line |
| h_sync_pos | input | HCW | Horizontal sync start count |
| sync_widths | input | 8 | [3:0] horizontal sync width, [7:4] vertical sync width |
| v_total | input | VCW | Last vertical row count of a frame |
| v_adjust | input | RCW | Extra adjust lines per frame |
| v_disp | input | VCW | Displayed character rows |
| v_sync_pos | input | VCW | Vertical sync start row |
| mode_ctl | input | 8 | [5:4] display-enable skew, [1:0] interlace (ignored) |
| row_max | input | RCW | Last raster row in a character row |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable, low in border |
| h_count | output | HCW | Horizontal character count |
| row_count | output | RCW | Raster row count |
| v_count | output | VCW | Vertical character row count |

## Verification
The bench builds two copies of the block on shared inputs. One copy uses `ZERO_HSYNC_OFF`=0, `FIXED_VSYNC`=0 and `VB_ROW_START`=0; the other sets all three to 1. This puts both meanings of a zero horizontal width, both vertical width sources and both border compare timings side by side. Four small timing sets are used, with lines of 10 to 16 characters and frames of 6 to 20 lines. Every character of four frames is therefore checked against an arithmetic model, including skew settings, zero widths, adjust lines and a one-row-per-character-row case. A directed step changes `v_disp` in the middle of a row to separate the two compare timings.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HCW = 8,
  parameter int VCW = 7,
  parameter int RCW = 5,
  parameter bit ZERO_HSYNC_OFF = 1'b0,
  parameter bit FIXED_VSYNC = 1'b0,
  parameter bit VB_ROW_START = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [HCW-1:0] h_total,
  input  logic [HCW-1:0] h_disp,
  input  logic [HCW-1:0] h_sync_pos,
  input  logic [7:0]     sync_widths,
  input  logic [VCW-1:0] v_total,
  input  logic [RCW-1:0] v_adjust,
  input  logic [VCW-1:0] v_disp,
  input  logic [VCW-1:0] v_sync_pos,
  input  logic [7:0]     mode_ctl,
  input  logic [RCW-1:0] row_max,
  output logic           hsync,
  output logic           vsync,
  output logic           disp_en,
  output logic [HCW-1:0] h_count,
  output logic [RCW-1:0] row_count,
  output logic [VCW-1:0] v_count
);
  localparam int SWW = 5;

  logic           in_adj, nadj;
  logic [HCW-1:0] nh;
  logic [RCW-1:0] nrow;
  logic [VCW-1:0] nv;
  logic [RCW:0]   row_inc;
  logic [SWW-1:0] hs_left, vs_left, hs_eff, vs_eff;
  logic           hb, vb, de_d1, de_d2;
  logic           line_end, vs_start, vb_eval, de_raw, de_sel;
  logic [1:0]     skew;

  wire unused_mode = ^{mode_ctl[7:6], mode_ctl[3:0]};

  assign line_end = (h_count == h_total);
  assign nh       = line_end ? '0 : h_count + HCW'(1);
  assign row_inc  = {1'b0, row_count} + (RCW+1)'(1);

  always_comb begin
    nrow = row_count;
    nv   = v_count;
    nadj = in_adj;
    if (line_end) begin
      if (in_adj) begin
        if (row_inc == {1'b0, v_adjust}) begin
          nrow = '0;
          nv   = '0;
          nadj = 1'b0;
        end else begin
          nrow = row_inc[RCW-1:0];
        end
      end else if (row_count == row_max) begin
        nrow = '0;
        if (v_count == v_total) begin
          if (v_adjust == '0) nv = '0;
          else nadj = 1'b1;
        end else begin
          nv = v_count + VCW'(1);
        end
      end else begin
        nrow = row_inc[RCW-1:0];
      end
    end
  end

  assign hs_eff = (sync_widths[3:0] == 4'd0) ? (ZERO_HSYNC_OFF ? 5'd0 : 5'd16)
                                             : {1'b0, sync_widths[3:0]};
  assign vs_eff = (FIXED_VSYNC || sync_widths[7:4] == 4'd0) ? 5'd16
                                                            : {1'b0, sync_widths[7:4]};
  assign vs_start = (nv == v_sync_pos) && (nrow == '0) && !nadj;
  assign vb_eval  = VB_ROW_START ? ((nh == '0) && (nrow == '0)) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_count   <= '0;
      row_count <= '0;
      v_count   <= '0;
      in_adj    <= 1'b0;
      hsync     <= 1'b0;
      hs_left   <= '0;
      vsync     <= 1'b0;
      vs_left   <= '0;
      hb        <= 1'b1;
      vb        <= 1'b1;
      de_d1     <= 1'b0;
      de_d2     <= 1'b0;
    end else if (ce) begin
      h_count   <= nh;
      row_count <= nrow;
      v_count   <= nv;
      in_adj    <= nadj;

      if (nh == h_sync_pos && hs_eff != '0) begin
        hsync   <= 1'b1;
        hs_left <= hs_eff - SWW'(1);
      end else if (hsync) begin
        if (hs_left == '0) hsync <= 1'b0;
        else hs_left <= hs_left - SWW'(1);
      end

      if (line_end) begin
        if (vs_start) begin
          vsync   <= 1'b1;
          vs_left <= vs_eff - SWW'(1);
        end else if (vsync) begin
          if (vs_left == '0) vsync <= 1'b0;
          else vs_left <= vs_left - SWW'(1);
        end
      end

      if (nh == h_disp) hb <= 1'b1;
      else if (nh == '0) hb <= 1'b0;

      if (vb_eval) begin
        if (nv == v_disp) vb <= 1'b1;
        else if (nv == '0) vb <= 1'b0;
      end

      de_d1 <= de_raw;
      de_d2 <= de_d1;
    end
  end

  assign skew   = mode_ctl[5:4];
  assign de_raw = ~(hb | vb);
  assign de_sel = (skew == 2'b00) ? de_raw : (skew == 2'b01) ? de_d1 : de_d2;
  assign disp_en = de_sel & (skew != 2'b11);

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int HCW = 8,
  parameter int VCW = 7,
  parameter int RCW = 5,
  parameter bit ZERO_HSYNC_OFF = 1'b0
) (
  input logic           clk,
  input logic           rst,
  input logic           ce,
  input logic [HCW-1:0] h_total,
  input logic [HCW-1:0] h_disp,
  input logic [HCW-1:0] h_sync_pos,
  input logic [7:0]     sync_widths,
  input logic [VCW-1:0] v_sync_pos,
  input logic [7:0]     mode_ctl,
  input logic           hsync,
  input logic           vsync,
  input logic           disp_en,
  input logic [HCW-1:0] h_count,
  input logic [RCW-1:0] row_count,
  input logic [VCW-1:0] v_count
);
  p_h_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (ce && h_count == h_total) |=> (h_count == '0));

  p_h_step_r1: assert property (@(posedge clk) disable iff (rst)
    (ce && h_count != h_total) |=> (h_count == $past(h_count) + HCW'(1)));

  p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && h_count != h_total) |=> ($stable(row_count) && $stable(v_count)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(h_count) && $stable(row_count) && $stable(v_count) &&
             $stable(hsync) && $stable(vsync)));

  p_hsync_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (h_count == h_sync_pos));

  p_no_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (ZERO_HSYNC_OFF && sync_widths[3:0] == 4'd0 && !hsync) |=> !hsync);

  p_vsync_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (h_count == '0 && row_count == '0 && v_count == v_sync_pos));

  p_hborder_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_ctl[5:4] == 2'b00 && h_disp <= h_total && h_count >= h_disp) |-> !disp_en);

  p_forced_off_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_ctl[5:4] == 2'b11) |-> !disp_en);
endmodule

bind raster_timing_gen raster_timing_chk #(
  .HCW(HCW), .VCW(VCW), .RCW(RCW), .ZERO_HSYNC_OFF(ZERO_HSYNC_OFF)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .h_total(h_total), .h_disp(h_disp),
  .h_sync_pos(h_sync_pos), .sync_widths(sync_widths), .v_sync_pos(v_sync_pos),
  .mode_ctl(mode_ctl), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
  .h_count(h_count), .row_count(row_count), .v_count(v_count)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, ce;
  logic [7:0] r0, r1, r2, r3, r8;
  logic [6:0] r4, r6, r7;
  logic [4:0] r5, r9;

  logic       hs_a, vs_a, de_a, hs_b, vs_b, de_b;
  logic [7:0] hc_a, hc_b;
  logic [4:0] rc_a, rc_b;
  logic [6:0] vc_a, vc_b;

  raster_timing_gen #(.ZERO_HSYNC_OFF(1'b0), .FIXED_VSYNC(1'b0), .VB_ROW_START(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .h_total(r0), .h_disp(r1), .h_sync_pos(r2),
    .sync_widths(r3), .v_total(r4), .v_adjust(r5), .v_disp(r6), .v_sync_pos(r7),
    .mode_ctl(r8), .row_max(r9), .hsync(hs_a), .vsync(vs_a), .disp_en(de_a),
    .h_count(hc_a), .row_count(rc_a), .v_count(vc_a));

  raster_timing_gen #(.ZERO_HSYNC_OFF(1'b1), .FIXED_VSYNC(1'b1), .VB_ROW_START(1'b1)) dut_b (
    .clk(clk), .rst(rst), .ce(ce), .h_total(r0), .h_disp(r1), .h_sync_pos(r2),
    .sync_widths(r3), .v_total(r4), .v_adjust(r5), .v_disp(r6), .v_sync_pos(r7),
    .mode_ctl(r8), .row_max(r9), .hsync(hs_b), .vsync(vs_b), .disp_en(de_b),
    .h_count(hc_b), .row_count(rc_b), .v_count(vc_b));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mh, mrow, mv, frame_chars;
  bit madj, hb;
  int hsl[2], vsl[2], hw[2], vw[2];
  bit vb[2], raw[2], d1[2], d2[2];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_de(input int k);
    case (r8[5:4])
      2'b00: return raw[k];
      2'b01: return d1[k];
      2'b10: return d2[k];
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_cfg(input int c);
    case (c)
      0: begin r0=9;  r1=6;  r2=7;  r3=8'h32; r4=5; r5=2; r6=4; r7=4; r8=8'h00; r9=2; end
      1: begin r0=11; r1=8;  r2=3;  r3=8'h00; r4=4; r5=0; r6=3; r7=2; r8=8'h13; r9=1; end
      2: begin r0=15; r1=10; r2=12; r3=8'h15; r4=3; r5=3; r6=2; r7=1; r8=8'h20; r9=3; end
      default: begin r0=9; r1=5; r2=6; r3=8'h23; r4=4; r5=1; r6=3; r7=3; r8=8'h30; r9=0; end
    endcase
    hw[0] = (r3[3:0] == 0) ? 16 : int'(r3[3:0]);
    hw[1] = int'(r3[3:0]);
    vw[0] = (r3[7:4] == 0) ? 16 : int'(r3[7:4]);
    vw[1] = 16;
    frame_chars = (int'(r0)+1) * ((int'(r4)+1)*(int'(r9)+1) + int'(r5));
  endtask

  task automatic model_reset();
    mh = 0; mrow = 0; mv = 0; madj = 0; hb = 1;
    for (int k = 0; k < 2; k++) begin
      hsl[k] = 0; vsl[k] = 0; vb[k] = 1; raw[k] = 0; d1[k] = 0; d2[k] = 0;
    end
  endtask

  task automatic model_step();
    bit le;
    le = (mh == int'(r0));
    for (int k = 0; k < 2; k++) begin
      d2[k] = d1[k];
      d1[k] = raw[k];
    end
    mh = le ? 0 : mh + 1;
    if (le) begin
      if (madj) begin
        if (mrow + 1 == int'(r5)) begin mrow = 0; mv = 0; madj = 0; end
        else mrow++;
      end else if (mrow == int'(r9)) begin
        mrow = 0;
        if (mv == int'(r4)) begin
          if (r5 == 0) mv = 0;
          else madj = 1;
        end else mv++;
      end else mrow++;
    end
    for (int k = 0; k < 2; k++) begin
      if (mh == int'(r2) && hw[k] != 0) hsl[k] = hw[k];
      else if (hsl[k] > 0) hsl[k]--;
      if (le) begin
        if (mv == int'(r7) && mrow == 0 && !madj) vsl[k] = vw[k];
        else if (vsl[k] > 0) vsl[k]--;
      end
    end
    if (mh == int'(r1)) hb = 1;
    else if (mh == 0) hb = 0;
    if (mv == int'(r6)) vb[0] = 1;
    else if (mv == 0) vb[0] = 0;
    if (mh == 0 && mrow == 0) begin
      if (mv == int'(r6)) vb[1] = 1;
      else if (mv == 0) vb[1] = 0;
    end
    for (int k = 0; k < 2; k++) raw[k] = !(hb || vb[k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ce = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    chk(hc_a == 0 && rc_a == 0 && vc_a == 0, "R10", "reset counters",
        int'(hc_a) + int'(rc_a) + int'(vc_a), 0);
    chk(!hs_a && !vs_a && !hs_b && !vs_b, "R10", "reset syncs",
        int'(hs_a) + int'(vs_a) + int'(hs_b) + int'(vs_b), 0);
    chk(!de_a && !de_b, "R10", "reset disp_en", int'(de_a) + int'(de_b), 0);
  endtask

  task automatic run_chars(input int n, input bit gap);
    int done_chars = 0;
    int cyc = 0;
    string tc, tde;
    while (done_chars < n) begin
      ce = !(gap && (cyc % 3 == 2));
      if (ce) begin model_step(); done_chars++; end
      @(negedge clk);
      tc  = !ce ? "R3" : (r8[1:0] != 0) ? "R9" : "R1/R2";
      tde = (r8[5:4] == 0) ? "R6" : "R7";
      chk(int'(hc_a) == mh && int'(rc_a) == mrow && int'(vc_a) == mv, tc, "counters",
          int'(hc_a)*65536 + int'(rc_a)*256 + int'(vc_a), mh*65536 + mrow*256 + mv);
      chk(hc_b == hc_a && rc_b == rc_a && vc_b == vc_a, "R2", "variant counters",
          int'(hc_b), int'(hc_a));
      chk(hs_a == (hsl[0] > 0), "R4", "hsync zero=16 variant", int'(hs_a), int'(hsl[0] > 0));
      chk(hs_b == (hsl[1] > 0), "R4", "hsync zero=off variant", int'(hs_b), int'(hsl[1] > 0));
      chk(vs_a == (vsl[0] > 0), "R5", "vsync register width", int'(vs_a), int'(vsl[0] > 0));
      chk(vs_b == (vsl[1] > 0), "R5", "vsync fixed width", int'(vs_b), int'(vsl[1] > 0));
      chk(de_a == exp_de(0), tde, "disp_en per-char compare", int'(de_a), int'(exp_de(0)));
      chk(de_b == exp_de(1), "R8", "disp_en row-start compare", int'(de_b), int'(exp_de(1)));
      cyc++;
    end
  endtask

  initial begin
    rst = 1; ce = 0;
    set_cfg(0);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      set_cfg(c);
      do_reset();
      run_chars(4 * frame_chars, (c % 2) == 1);
    end

    set_cfg(0);
    do_reset();
    run_chars(frame_chars, 1'b0);
    while (!(mv == 1 && mrow == 1 && mh == 3)) run_chars(1, 1'b0);
    r6 = 1; ce = 1;
    @(negedge clk);
    chk(de_a == 1'b0, "R8", "mid-row v_disp change, per-char compare", int'(de_a), 0);
    chk(de_b == 1'b1, "R8", "mid-row v_disp change, row-start compare", int'(de_b), 1);
    @(negedge clk);
    chk(de_b == 1'b1 && hc_b == 8'd5, "R8", "row-start variant still displaying", int'(de_b), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule